// File: doc/BRIEF.md
# Per-Lane Event Counter

This block is the single statistics counter attached to one root port of a serial link controller. Around it, the data-link layer and the transaction layer each raise one strobe per lane whenever one of their events occurs. Software picks one event and one lane through a control write. From then on the counter adds one for every cycle in which that strobe is high.

The event is named by a 12-bit code. Its upper nibble picks the group: 6 for the link-layer events and 7 for the transaction-layer packet types. The low bits pick the event inside that group. The count never clears itself. It holds its value across disable and across a new selection until software writes the clear command. Near the top of its range it saturates instead of wrapping. The block raises no interrupt.

Top module: `lane_evt_counter`

## Requirements
- R1: After a synchronous reset, `count_q` is zero and counting is disabled. Strobes have no effect until a control write sets the enable bit.
- R2: Codes 0x600 to 0x606 select link-layer event e = code - 0x600. For lane l, the strobe counted is `ev_link[e*NUM_LANES + l]`.
- R3: Codes 0x700 to 0x717, leaving out 0x70D and 0x70E, select packet event t = code - 0x700. For lane l, the strobe counted is `ev_tlp[t*NUM_LANES + l]`.
- R4: Any other code, including 0x607, 0x70D, 0x70E, 0x718 and up, and codes outside groups 6 and 7, never increments the count.
- R5: A selected lane index that is not below `link_width` never increments the count.
- R6: While enabled, each cycle in which the selected strobe is high adds exactly one. The new value appears on `count_q` after that same clock edge.
- R7: While disabled, `count_q` holds its value whatever the strobes do.
- R8: A control write with `ctl_clear` set zeroes the count at that edge, whatever the enable bit is. Without a clear, the count is kept across disable, re-enable and a change of selection.
- R9: The count saturates at all ones and stays there until it is cleared.
- R10: In the cycle of a control write the count does not increment. The new selection and enable take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_code | input | 12 | Event code to select |
| ctl_lane | input | LANE_W | Lane index to select |
| ctl_enable | input | 1 | Counting enable written with the control word |
| ctl_clear | input | 1 | Clear command written with the control word |
| link_width | input | LANE_W+1 | Number of active lanes |
| ev_link | input | 7*NUM_LANES | Link-layer event strobes, event-major, lane-minor |
| ev_tlp | input | 24*NUM_LANES | Packet-type event strobes, event-major, lane-minor |
| count_q | output | CNT_W | Registered event count |

## Verification
The case hardest to reach from the ports is saturation, because it takes 2^CNT_W strobes. The bench therefore builds the counter 8 bits wide, holds every strobe high for far more cycles than that, and then checks that the count stays at all ones until a clear. It also sweeps every code in both groups, plus codes just around them, across every lane. Each selection runs under random strobes on all inputs, and the expected count is the number of cycles in which the selected bit was high. Unassigned codes and lanes beyond the link width must therefore stay at zero while the other strobes toggle.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int LINK_EVTS = 7;
  localparam int TLP_EVTS  = 24;
  localparam int LINK_IDX_W = 3;
  localparam int TLP_IDX_W  = 5;

  typedef enum logic [1:0] {SRC_NONE, SRC_LINK, SRC_TLP} src_e;

  function automatic src_e code_source(input logic [11:0] code);
    logic [7:0] idx;
    idx = code[7:0];
    if (code[11:8] == 4'h6 && idx < 8'(LINK_EVTS))
      return SRC_LINK;
    else if (code[11:8] == 4'h7 && idx < 8'(TLP_EVTS) && idx != 8'h0D && idx != 8'h0E)
      return SRC_TLP;
    else
      return SRC_NONE;
  endfunction
endpackage

// File: rtl/lec_ctrl_reg.sv
module lec_ctrl_reg #(
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [11:0]       code_in,
  input  logic [LANE_W-1:0] lane_in,
  input  logic              en_in,
  output logic [11:0]       code_q,
  output logic [LANE_W-1:0] lane_q,
  output logic              en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      lane_q <= '0;
      en_q   <= 1'b0;
    end else if (wr) begin
      code_q <= code_in;
      lane_q <= lane_in;
      en_q   <= en_in;
    end
  end
endmodule

// File: rtl/lec_event_select.sv
module lec_event_select #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 2
) (
  input  logic [11:0]                             code,
  input  logic [LANE_W-1:0]                       lane,
  input  logic [LANE_W:0]                         link_width,
  input  logic [lec_pkg::LINK_EVTS*NUM_LANES-1:0] ev_link,
  input  logic [lec_pkg::TLP_EVTS*NUM_LANES-1:0]  ev_tlp,
  output logic                                    hit
);
  localparam int LANE_SLOTS = 1 << LANE_W;
  localparam int LINK_SLOTS = 1 << lec_pkg::LINK_IDX_W;
  localparam int TLP_SLOTS  = 1 << lec_pkg::TLP_IDX_W;

  logic [LANE_SLOTS-1:0] link_tab [LINK_SLOTS];
  logic [LANE_SLOTS-1:0] tlp_tab  [TLP_SLOTS];

  for (genvar e = 0; e < LINK_SLOTS; e++) begin : g_link
    if (e < lec_pkg::LINK_EVTS) begin : g_used
      assign link_tab[e] = LANE_SLOTS'(ev_link[e*NUM_LANES +: NUM_LANES]);
    end else begin : g_pad
      assign link_tab[e] = '0;
    end
  end

  for (genvar t = 0; t < TLP_SLOTS; t++) begin : g_tlp
    if (t < lec_pkg::TLP_EVTS) begin : g_used
      assign tlp_tab[t] = LANE_SLOTS'(ev_tlp[t*NUM_LANES +: NUM_LANES]);
    end else begin : g_pad
      assign tlp_tab[t] = '0;
    end
  end

  lec_pkg::src_e src;
  logic          lane_ok;
  logic [LANE_SLOTS-1:0] lanes;

  always_comb begin
    src     = lec_pkg::code_source(code);
    lane_ok = ({1'b0, lane} < link_width);
    case (src)
      lec_pkg::SRC_LINK: lanes = link_tab[code[lec_pkg::LINK_IDX_W-1:0]];
      lec_pkg::SRC_TLP:  lanes = tlp_tab[code[lec_pkg::TLP_IDX_W-1:0]];
      default:           lanes = '0;
    endcase
    hit = lane_ok && lanes[lane];
  end
endmodule

// File: rtl/lec_sat_counter.sv
module lec_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hold,
  input  logic             inc,
  output logic [CNT_W-1:0] count_q
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)
      count_q <= '0;
    else if (!hold && inc && count_q != TOP)
      count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter #(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 32,
  localparam int LANE_W   = (NUM_LANES > 2) ? $clog2(NUM_LANES) : 1
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    ctl_wr,
  input  logic [11:0]                             ctl_code,
  input  logic [LANE_W-1:0]                       ctl_lane,
  input  logic                                    ctl_enable,
  input  logic                                    ctl_clear,
  input  logic [LANE_W:0]                         link_width,
  input  logic [lec_pkg::LINK_EVTS*NUM_LANES-1:0] ev_link,
  input  logic [lec_pkg::TLP_EVTS*NUM_LANES-1:0]  ev_tlp,
  output logic [CNT_W-1:0]                        count_q
);
  logic [11:0]       sel_code;
  logic [LANE_W-1:0] sel_lane;
  logic              sel_en;
  logic              ev_hit;

  lec_ctrl_reg #(.LANE_W(LANE_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr(ctl_wr),
    .code_in(ctl_code), .lane_in(ctl_lane), .en_in(ctl_enable),
    .code_q(sel_code), .lane_q(sel_lane), .en_q(sel_en)
  );

  lec_event_select #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_sel (
    .code(sel_code), .lane(sel_lane), .link_width(link_width),
    .ev_link(ev_link), .ev_tlp(ev_tlp), .hit(ev_hit)
  );

  lec_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .clr(ctl_wr && ctl_clear),
    .hold(ctl_wr),
    .inc(sel_en && ev_hit),
    .count_q(count_q)
  );
endmodule

// File: rtl/lec_checker.sv
module lec_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_wr,
  input logic             ctl_clear,
  input logic [CNT_W-1:0] count_q
);
  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_clear) |=> (count_q == '0));

  // R8
  no_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr && ctl_clear) |=> (count_q >= $past(count_q)));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr && ctl_clear) |=> ((count_q - $past(count_q)) <= CNT_W'(1)));

  // R9
  saturate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((count_q == {CNT_W{1'b1}}) && !(ctl_wr && ctl_clear)) |=> (count_q == {CNT_W{1'b1}}));

  // R10
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_clear) |=> $stable(count_q));
endmodule

bind lane_evt_counter lec_checker #(.CNT_W(CNT_W)) u_lec_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_clear(ctl_clear), .count_q(count_q)
);

// File: tb/lane_evt_counter_test.sv
module lane_evt_counter_test;
  localparam int NL = 4;
  localparam int CW = 8;
  localparam int LW = 2;
  localparam int LINKW = 7*NL;
  localparam int TLPW  = 24*NL;

  logic clk = 0;
  logic rst = 1;
  logic ctl_wr = 0;
  logic [11:0] ctl_code = '0;
  logic [LW-1:0] ctl_lane = '0;
  logic ctl_enable = 0;
  logic ctl_clear = 0;
  logic [LW:0] link_width = 3'(NL);
  logic [LINKW-1:0] ev_link = '0;
  logic [TLPW-1:0] ev_tlp = '0;
  logic [CW-1:0] count_q;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lane_evt_counter #(.NUM_LANES(NL), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_code(ctl_code),
    .ctl_lane(ctl_lane), .ctl_enable(ctl_enable), .ctl_clear(ctl_clear),
    .link_width(link_width), .ev_link(ev_link), .ev_tlp(ev_tlp),
    .count_q(count_q)
  );

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(count_q) != exp) begin
      fails++;
      $display("FAIL %s: count_q=%0d expected=%0d", req, count_q, exp);
    end
  endtask

  // expected strobe bit for a selection, from R2..R5
  function automatic bit sel_bit(input logic [11:0] code, input int lane);
    int idx;
    idx = int'(code[7:0]);
    if (lane >= int'(link_width)) return 0;
    if (code[11:8] == 4'h6 && idx < 7) return ev_link[idx*NL + lane];
    if (code[11:8] == 4'h7 && idx < 24 && idx != 13 && idx != 14) return ev_tlp[idx*NL + lane];
    return 0;
  endfunction

  // called at negedge; write takes effect at next posedge
  task automatic write_ctl(input logic [11:0] code, input int lane, input bit en, input bit clr);
    ctl_wr = 1; ctl_code = code; ctl_lane = LW'(lane);
    ctl_enable = en; ctl_clear = clr;
    @(negedge clk);
    ctl_wr = 0; ctl_clear = 0;
  endtask

  task automatic randomize_strobes();
    ev_link = LINKW'({$urandom, $urandom});
    ev_tlp  = TLPW'({$urandom, $urandom, $urandom, $urandom});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: count_q=%0d expected=finished run", count_q);
    finish_run();
  end

  initial begin
    int exp;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state and disabled after reset
    check("R1 reset value", 0);
    ev_link = '1; ev_tlp = '1;
    repeat (5) @(negedge clk);
    check("R1 disabled after reset", 0);

    // R2 R3 R4 sweep of codes around both groups and all lanes
    for (int g = 5; g <= 8; g++) begin
      for (int i = 0; i < 26; i++) begin
        for (int l = 0; l < NL; l++) begin
          logic [11:0] code;
          code = {4'(g), 8'(i)};
          randomize_strobes();
          write_ctl(code, l, 1, 1);
          exp = 0;
          for (int c = 0; c < 6; c++) begin
            randomize_strobes();
            exp += int'(sel_bit(code, l));
            @(negedge clk);
          end
          ev_link = '0; ev_tlp = '0;
          if (g == 6 && i < 7) check("R2 link event count", exp);
          else if (g == 7 && i < 24 && i != 13 && i != 14) check("R3 packet event count", exp);
          else check("R4 unassigned code", 0);
        end
      end
    end

    // R5 lanes at or beyond link width count nothing
    link_width = 3'd2;
    for (int l = 0; l < NL; l++) begin
      write_ctl(12'h603, l, 1, 1);
      ev_link = '1;
      repeat (4) @(negedge clk);
      ev_link = '0;
      check("R5 lane versus link width", (l < 2) ? 4 : 0);
    end
    link_width = 3'(NL);

    // R6 exact per-cycle increment on a fixed pattern
    write_ctl(12'h716, 3, 1, 1);
    for (int c = 0; c < 10; c++) begin
      ev_tlp = '0;
      ev_tlp[22*NL + 3] = (c % 3 == 0);
      @(negedge clk);
      check("R6 running count", (c / 3) + 1);
    end
    ev_tlp = '0;

    // R7 disable holds value; R8 no self clear across re-enable
    write_ctl(12'h716, 3, 0, 0);
    check("R8 count kept on disable", 4);
    ev_tlp = '1;
    repeat (5) @(negedge clk);
    check("R7 disabled holds", 4);
    ev_tlp = '0;
    write_ctl(12'h601, 1, 1, 0);
    ev_link = '1;
    repeat (3) @(negedge clk);
    ev_link = '0;
    check("R8 count kept on new selection", 7);

    // R10 write cycle with strobes high does not increment
    ev_link = '1;
    write_ctl(12'h601, 1, 1, 0);
    ev_link = '0;
    check("R10 write cycle no increment", 7);

    // R8 clear with enable off, count stays zero
    ev_link = '1;
    write_ctl(12'h601, 1, 0, 1);
    check("R8 clear with enable off", 0);
    repeat (4) @(negedge clk);
    check("R8 stays zero until enabled", 0);
    ev_link = '0;

    // R9 saturation
    write_ctl(12'h600, 0, 1, 1);
    ev_link = '1;
    repeat ((1 << CW) + 40) @(negedge clk);
    check("R9 saturates at all ones", (1 << CW) - 1);
    repeat (10) @(negedge clk);
    check("R9 stays saturated", (1 << CW) - 1);
    write_ctl(12'h600, 0, 1, 1);
    check("R8 clear from saturation", 0);
    @(negedge clk);
    check("R6 counts after clear", 1);
    ev_link = '0;

    finish_run();
  end
endmodule